// File: doc/BRIEF.md
# Static Memory Strobe Timing Generator

This block drives the chip-select, read strobe and write strobe of an asynchronous static-memory or IDE-style bus for one access at a time. A requester raises `req` with the direction and the data width. The block accepts the request when it is idle and captures the timing inputs: setup, pulse, cycle and chip-select pulse counts, a float count, and a ready-wait enable. It then counts the access out in clocks. Reads and writes use the same timing values.

Chip-select stays low for the whole access. The access length is the largest of three values: the cycle count, setup plus pulse, and the chip-select pulse count. A strobe can therefore never outlast its cycle. When ready-wait is enabled, an external ready line passes through two synchronizing flops. While that synchronized line is low, it freezes the access inside the strobe phase. Read data is captured on the clock edge that ends the strobe. After a read, a float interval keeps the bus idle before another access may start.

Top module: `smem_strobe_gen`

## Requirements
- R1: While reset is asserted, and after it is released with no request, `mem_cs_n`, `mem_rd_n` and `mem_wr_n` are 1, while `ack` and `mem_d_oe` are 0.
- R2: An access is accepted on the rising edge where `req` is 1, no access is running, `ack` is 0 and the float count has run out. `mem_cs_n` is 0 from the next clock for exactly C clocks, where C = max(cycle, setup + P, cs_pulse), P = pulse, and a pulse of 0 counts as 1.
- R3: Number the clocks of the access from 0. The strobe is low from clock `setup` for P clocks. Reads drive `mem_rd_n` and writes (`req_wr`=1) drive `mem_wr_n`. The other strobe stays 1.
- R4: `ack` is 1 for exactly one clock: the first clock after the last clock of the access. `mem_cs_n` is 1 in that clock.
- R5: A read stores `mem_d_in` on the edge that ends its last strobe clock. A 16-bit read (`req_wide`=1) stores all of bits [15:0]. An 8-bit read stores bits [7:0] and zeroes [15:8]. `rdata` holds the stored value in the `ack` clock and keeps it until the next read stores new data.
- R6: During every chip-select-low clock of a write, `mem_d_oe` is 1. `mem_d_out` equals `wdata`, with bits [15:8] forced to 0 for an 8-bit write. `mem_d_oe` is 0 during reads.
- R7: With `cfg_rdy_wait`=1, each strobe clock in which the twice-synchronized `mem_rdy` is 0 does not advance the access. If `mem_rdy` has been 0 since before the strobe and rises during strobe clock j, the strobe and chip-select each last j+2 clocks longer than without waiting.
- R8: With `cfg_rdy_wait`=0, `mem_rdy` has no effect on strobe or chip-select length.
- R9: With `req` held at 1, the number of clocks `mem_cs_n` stays 1 between two accesses, counting the `ack` clock, is max(F,1)+1 after a read with float count F. After a write it is 2, whatever the float count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_setup | input | 10 | Setup clocks before the strobe |
| cfg_pulse | input | 10 | Strobe clocks (0 treated as 1) |
| cfg_cycle | input | 10 | Minimum access length in clocks |
| cfg_cs_pulse | input | 10 | Minimum chip-select length in clocks |
| cfg_float | input | 4 | Idle float clocks after a read |
| cfg_rdy_wait | input | 1 | Enable stretching the strobe by the ready line |
| req | input | 1 | Access request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit, 0 = 8-bit |
| wdata | input | 16 | Write data |
| ack | output | 1 | One-clock access completion |
| rdata | output | 16 | Captured read data |
| mem_cs_n | output | 1 | Chip-select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_d_out | output | 16 | Bus data driven on writes |
| mem_d_oe | output | 1 | Bus output enable |
| mem_bus16 | output | 1 | Width of the current access |
| mem_d_in | input | 16 | Bus data sampled on reads |
| mem_rdy | input | 1 | Asynchronous ready line from the device |

## Verification
The hardest case to reach from the ports is a ready line that releases in a known strobe clock. The release must be aligned with the two synchronizing flops, so that the exact number of stalled clocks can be predicted. The stimulus holds `mem_rdy` low well before the access. It counts strobe clocks at falling edges and raises the line right after strobe clock 1, so three stalled clocks are expected. The float interval is reached by holding `req` high across back-to-back accesses and counting the idle chip-select clocks.

// File: rtl/smem_strobe_gen.sv
module smem_strobe_gen #(
  parameter int CW = 10,
  parameter int FW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_setup,
  input  logic [CW-1:0] cfg_pulse,
  input  logic [CW-1:0] cfg_cycle,
  input  logic [CW-1:0] cfg_cs_pulse,
  input  logic [FW-1:0] cfg_float,
  input  logic          cfg_rdy_wait,
  input  logic          req,
  input  logic          req_wr,
  input  logic          req_wide,
  input  logic [DW-1:0] wdata,
  output logic          ack,
  output logic [DW-1:0] rdata,
  output logic          mem_cs_n,
  output logic          mem_rd_n,
  output logic          mem_wr_n,
  output logic [DW-1:0] mem_d_out,
  output logic          mem_d_oe,
  output logic          mem_bus16,
  input  logic [DW-1:0] mem_d_in,
  input  logic          mem_rdy
);
  localparam int TW = CW + 1;
  localparam int HW = DW / 2;

  logic          busy, ack_q, wr_l, wide_l, rdy_l;
  logic [TW-1:0] cnt, set_l, end_l, len_l;
  logic [FW-1:0] flt_l, flt;
  logic [DW-1:0] wd_l, rd_q;
  logic [1:0]    rsync;

  logic [TW-1:0] p_eff, se_sum, c_max1, c_eff;
  assign p_eff  = (cfg_pulse == '0) ? TW'(1) : TW'(cfg_pulse);
  assign se_sum = TW'(cfg_setup) + p_eff;
  assign c_max1 = (TW'(cfg_cycle) > se_sum) ? TW'(cfg_cycle) : se_sum;
  assign c_eff  = (TW'(cfg_cs_pulse) > c_max1) ? TW'(cfg_cs_pulse) : c_max1;

  logic start, strobe, stall, last, cap;
  assign start  = !busy && !ack_q && (flt == '0) && req;
  assign strobe = busy && (cnt >= set_l) && (cnt < end_l);
  assign stall  = strobe && rdy_l && !rsync[1];
  assign last   = busy && !stall && (cnt == len_l - TW'(1));
  assign cap    = strobe && !stall && !wr_l && (cnt == end_l - TW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= '0;
    else        rsync <= {rsync[0], mem_rdy};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      ack_q  <= 1'b0;
      cnt    <= '0;
      set_l  <= '0;
      end_l  <= '0;
      len_l  <= '0;
      wr_l   <= 1'b0;
      wide_l <= 1'b0;
      rdy_l  <= 1'b0;
      flt_l  <= '0;
      flt    <= '0;
      wd_l   <= '0;
    end else begin
      ack_q <= last;
      if (start) begin
        busy   <= 1'b1;
        cnt    <= '0;
        set_l  <= TW'(cfg_setup);
        end_l  <= se_sum;
        len_l  <= c_eff;
        wr_l   <= req_wr;
        wide_l <= req_wide;
        rdy_l  <= cfg_rdy_wait;
        flt_l  <= cfg_float;
        wd_l   <= wdata;
      end else if (busy && !stall) begin
        cnt <= cnt + TW'(1);
        if (last) busy <= 1'b0;
      end
      if (last)              flt <= wr_l ? '0 : flt_l;
      else if (flt != '0)    flt <= flt - FW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rd_q <= '0;
    else if (cap) rd_q <= wide_l ? mem_d_in : {{(DW-HW){1'b0}}, mem_d_in[HW-1:0]};
  end

  assign ack       = ack_q;
  assign rdata     = rd_q;
  assign mem_cs_n  = !busy;
  assign mem_rd_n  = !(strobe && !wr_l);
  assign mem_wr_n  = !(strobe && wr_l);
  assign mem_d_oe  = busy && wr_l;
  assign mem_d_out = wide_l ? wd_l : {{(DW-HW){1'b0}}, wd_l[HW-1:0]};
  assign mem_bus16 = wide_l;
endmodule

// File: rtl/smem_strobe_gen_chk.sv
module smem_strobe_gen_chk #(
  parameter int FW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_cs_n,
  input logic          mem_rd_n,
  input logic          mem_wr_n,
  input logic          mem_d_oe,
  input logic          ack,
  input logic          stall,
  input logic [FW-1:0] flt
);
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_rd_n && !mem_wr_n));
  a_r3_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd_n || !mem_wr_n) |-> !mem_cs_n);
  a_r4_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  a_r4_ack_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> mem_cs_n);
  a_r4_ack_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cs_n) |-> ack);
  a_r6_oe_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_n |-> mem_d_oe);
  a_r6_oe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    mem_d_oe |-> !mem_cs_n);
  a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (!mem_rd_n || !mem_wr_n));
  a_r9_float_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_cs_n) |-> ($past(flt) == '0));
endmodule

bind smem_strobe_gen smem_strobe_gen_chk #(.FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n),
  .mem_wr_n(mem_wr_n), .mem_d_oe(mem_d_oe), .ack(ack), .stall(stall), .flt(flt)
);

// File: tb/test_smem_strobe_gen.sv
module test_smem_strobe_gen;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        wr;
    logic        wide;
    logic [9:0]  s;
    logic [9:0]  p;
    logic [9:0]  c;
    logic [9:0]  cp;
    logic [3:0]  f;
    logic [15:0] wd;
    logic [15:0] din;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 1'b1, 10'd1, 10'd2, 10'd5,  10'd0, 4'd0, 16'h0000, 16'hA55A},
    '{1'b0, 1'b0, 10'd0, 10'd3, 10'd2,  10'd0, 4'd3, 16'h0000, 16'h1234},
    '{1'b1, 1'b1, 10'd2, 10'd1, 10'd3,  10'd6, 4'd7, 16'hBEEF, 16'h0000},
    '{1'b1, 1'b0, 10'd3, 10'd4, 10'd10, 10'd0, 4'd0, 16'hCAFE, 16'h0000},
    '{1'b0, 1'b1, 10'd0, 10'd0, 10'd0,  10'd0, 4'd0, 16'h0000, 16'h0F0F},
    '{1'b0, 1'b1, 10'd4, 10'd2, 10'd3,  10'd2, 4'd2, 16'h0000, 16'h8001}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [9:0] cfg_setup = '0, cfg_pulse = '0, cfg_cycle = '0, cfg_cs_pulse = '0;
  logic [3:0] cfg_float = '0;
  logic cfg_rdy_wait = 1'b0, req = 1'b0, req_wr = 1'b0, req_wide = 1'b0;
  logic [15:0] wdata = '0, mem_d_in = '0;
  logic mem_rdy = 1'b1;
  logic ack, mem_cs_n, mem_rd_n, mem_wr_n, mem_d_oe, mem_bus16;
  logic [15:0] rdata, mem_d_out;

  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smem_strobe_gen i_smem_strobe_gen (
    .clk(clk), .rst_n(rst_n), .cfg_setup(cfg_setup), .cfg_pulse(cfg_pulse),
    .cfg_cycle(cfg_cycle), .cfg_cs_pulse(cfg_cs_pulse), .cfg_float(cfg_float),
    .cfg_rdy_wait(cfg_rdy_wait), .req(req), .req_wr(req_wr), .req_wide(req_wide),
    .wdata(wdata), .ack(ack), .rdata(rdata), .mem_cs_n(mem_cs_n),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .mem_d_out(mem_d_out),
    .mem_d_oe(mem_d_oe), .mem_bus16(mem_bus16), .mem_d_in(mem_d_in),
    .mem_rdy(mem_rdy)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic setup_cfg(input logic wr, input logic wide, input int s, input int p,
                           input int c, input int cp, input int f, input logic [15:0] wd,
                           input logic [15:0] din, input logic rw);
    cfg_setup = 10'(s); cfg_pulse = 10'(p); cfg_cycle = 10'(c); cfg_cs_pulse = 10'(cp);
    cfg_float = 4'(f); cfg_rdy_wait = rw; req_wr = wr; req_wide = wide;
    wdata = wd; mem_d_in = din;
  endtask

  task automatic run(input logic wr, input logic wide, input int rel_at,
                     output int cs_len, output int st_start, output int st_len,
                     output int bad, output int ackok, output logic [15:0] rd);
    logic [15:0] exp_out;
    int guard;
    exp_out = wide ? wdata : {8'h00, wdata[7:0]};
    @(negedge clk);
    req = 1'b1;
    cs_len = 0; st_start = -1; st_len = 0; bad = 0; guard = 0;
    forever begin
      @(negedge clk);
      guard++;
      if (ack || guard > 2000) break;
      if (!mem_cs_n) begin
        if (wr ? !mem_wr_n : !mem_rd_n) begin
          if (st_start < 0) st_start = cs_len;
          st_len++;
          if (rel_at >= 0 && st_len == rel_at + 1) mem_rdy = 1'b1;
        end
        if (wr ? !mem_rd_n : !mem_wr_n) bad++;
        if (wr && (!mem_d_oe || mem_d_out !== exp_out)) bad++;
        if (!wr && mem_d_oe) bad++;
        if (mem_bus16 !== wide) bad++;
        cs_len++;
      end
    end
    ackok = (ack && mem_cs_n) ? 1 : 0;
    rd = rdata;
    req = 1'b0;
    @(negedge clk);
    if (ack) ackok = 0;
  endtask

  task automatic gap(input logic wr, input int f, output int idle);
    int guard;
    setup_cfg(wr, 1'b1, 1, 2, 4, 0, f, 16'h1111, 16'h2222, 1'b0);
    @(negedge clk);
    req = 1'b1;
    guard = 0;
    do begin @(negedge clk); guard++; end while (!ack && guard < 2000);
    idle = 1;
    forever begin
      @(negedge clk);
      guard++;
      if (!mem_cs_n || guard > 2000) break;
      idle++;
    end
    req = 1'b0;
    do begin @(negedge clk); guard++; end while (!ack && guard < 4000);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cs_len, st_start, st_len, bad, ackok, idle;
    logic [15:0] rd, last_rd;
    last_rd = '0;
    repeat (3) @(negedge clk);
    check("R1 cs_n in reset", int'(mem_cs_n), 1);
    check("R1 strobes in reset", int'({mem_rd_n, mem_wr_n}), 3);
    check("R1 ack/oe in reset", int'({ack, mem_d_oe}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 idle after reset", int'({mem_cs_n, mem_rd_n, mem_wr_n, ack, mem_d_oe}), 5'b11100);

    foreach (VECS[i]) begin
      vec_t v;
      int pe, c;
      v = VECS[i];
      pe = (v.p == 0) ? 1 : int'(v.p);
      c = int'(v.c);
      if (int'(v.s) + pe > c) c = int'(v.s) + pe;
      if (int'(v.cp) > c) c = int'(v.cp);
      setup_cfg(v.wr, v.wide, int'(v.s), int'(v.p), int'(v.c), int'(v.cp), int'(v.f), v.wd, v.din, 1'b0);
      run(v.wr, v.wide, -1, cs_len, st_start, st_len, bad, ackok, rd);
      if (!v.wr) last_rd = v.wide ? v.din : {8'h00, v.din[7:0]};
      check($sformatf("R2 vec%0d cs length", i), cs_len, c);
      check($sformatf("R3 vec%0d strobe start", i), st_start, int'(v.s));
      check($sformatf("R3 vec%0d strobe length", i), st_len, pe);
      check($sformatf("R6 vec%0d bus/oe/other strobe errors", i), bad, 0);
      check($sformatf("R4 vec%0d single ack after cs", i), ackok, 1);
      check($sformatf("R5 vec%0d rdata", i), int'(rd), int'(last_rd));
    end

    // R7: ready wait, release during strobe clock 1 -> 3 extra clocks
    mem_rdy = 1'b0;
    repeat (4) @(negedge clk);
    setup_cfg(1'b0, 1'b1, 2, 3, 4, 0, 0, 16'h0, 16'h5AA5, 1'b1);
    run(1'b0, 1'b1, 1, cs_len, st_start, st_len, bad, ackok, rd);
    check("R7 stretched strobe length", st_len, 6);
    check("R7 stretched cs length", cs_len, 8);
    check("R7 rdata after wait", int'(rd), 16'h5AA5);

    // R8: ready low but waiting disabled
    mem_rdy = 1'b0;
    repeat (4) @(negedge clk);
    setup_cfg(1'b1, 1'b1, 2, 3, 4, 0, 0, 16'h7E81, 16'h0, 1'b0);
    run(1'b1, 1'b1, -1, cs_len, st_start, st_len, bad, ackok, rd);
    check("R8 strobe length ignores ready", st_len, 3);
    check("R8 cs length ignores ready", cs_len, 5);
    mem_rdy = 1'b1;

    // R9: idle clocks between back-to-back accesses
    gap(1'b0, 5, idle);
    check("R9 gap after read float 5", idle, 6);
    gap(1'b0, 0, idle);
    check("R9 gap after read float 0", idle, 2);
    gap(1'b0, 1, idle);
    check("R9 gap after read float 1", idle, 2);
    gap(1'b1, 9, idle);
    check("R9 gap after write float ignored", idle, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule